// File: doc/BRIEF.md
# Pixel-Counted Video Timing Generator

This block turns a pixel clock into the raster control signals of a video output: horizontal sync, vertical sync, data enable, an active-window flag and a one-cycle fetch-start strobe. A single counter runs through every pixel clock of the frame. All vertical positions (frame length, vsync length, start and end of the displayed lines, start and end of the active sub-window, fetch position) are programmed as absolute pixel-clock counts from the start of the frame, not as line numbers. Horizontal positions are column numbers within a line.

Software programs the engine through a simple write port. The column counter and the line counter follow the frame counter. Inside the displayed region the output pixel is the upstream pixel when it lies inside the optional active sub-window, or a programmable border colour when it lies outside that window. A polarity register inverts any of the three sync and enable outputs. Configuration writes go to a pending copy that the engine adopts only at a frame boundary, or at once while the engine is stopped. Frame and line counters are brought out and read as zero while the engine is stopped.

Top module: `pxcount_timing_gen`

## Requirements
- R1: After reset, and whenever the enable register (address 0, bit 0) is clear, hsync_o, vsync_o and de_o sit at the level of their polarity bits, and fetch_o, win_o, pix_o, frame_cnt_o and line_cnt_o are zero.
- R2: Address 2 holds the line length in clocks in bits 31:16 and the hsync width in bits 15:0. hsync_o is active for columns 0 to width-1 of every line, and the column wraps to 0 after line length minus one.
- R3: vsync_o is active while the frame pixel count is at least the skew (address 12) and below the skew plus the vsync length (address 4, in clocks).
- R4: de_o is active when the frame pixel count lies in the inclusive range from address 5 to address 6 and the column lies in the inclusive range whose end is in bits 31:16 and whose start is in bits 15:0 of address 7.
- R5: Address 1 bit 29 enables a column window (address 8: end in bits 31:16, start in bits 15:0) and bit 30 enables a pixel-count window (address 9 start, address 10 end, inclusive). win_o is de active and inside every enabled window. pix_o is pix_i when win_o and pix_valid_i are set, 0 when win_o is set and pix_valid_i is clear, the border colour (address 11) when de is active outside the window, and 0 outside the displayed region.
- R6: Address 13 bit 0 inverts hsync_o, bit 1 inverts vsync_o and bit 2 inverts de_o.
- R7: When address 1 bit 31 is set, fetch_o is high for exactly the one clock in which the frame pixel count equals address 14. When bit 31 is clear, fetch_o stays low.
- R8: The frame pixel count wraps to 0 after the frame length (address 3) minus one. frame_cnt_o counts completed frames since enable, and line_cnt_o gives the current line within the frame.
- R9: Writes to addresses 1 to 14 while the engine runs do not change any output until the first clock of the next frame, and they fully apply from then on.
- R10: In the first clock after enable is set, the frame pixel count, column, line and frame counters all start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pix_i | input | COLW | Upstream pixel |
| pix_valid_i | input | 1 | Upstream pixel valid |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| win_o | output | 1 | Inside active sub-window |
| pix_o | output | COLW | Output pixel or border colour |
| fetch_o | output | 1 | Fetch-start strobe |
| frame_cnt_o | output | CNTW | Completed frames since enable |
| line_cnt_o | output | HW | Current line in frame |

## Verification
The assertions check on every cycle how the counters move: the frame count steps by one on each wrap and the pixel count returns to zero, a column wrap advances the line, a stopped engine holds its counters at zero, and the adopted configuration stays constant except at a frame boundary. They also check that the fetch strobe never lasts more than one clock inside a frame and that the counters start from zero. Only the bench scenarios show that the decoded waveforms land at the right pixel positions. They sweep every clock of several frames under three configurations with different skew, windows and polarity, switch configuration in the middle of a running frame, and compare each output against positions computed from the programmed geometry.

// File: rtl/pxcount_timing_gen.sv
module pxcount_timing_gen #(
  parameter int HW   = 16,
  parameter int PW   = 32,
  parameter int CNTW = 16,
  parameter int COLW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic [COLW-1:0] pix_i,
  input  logic            pix_valid_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            win_o,
  output logic [COLW-1:0] pix_o,
  output logic            fetch_o,
  output logic [CNTW-1:0] frame_cnt_o,
  output logic [HW-1:0]   line_cnt_o
);

  localparam logic [3:0] A_EN = 4'd0, A_MODE = 4'd1, A_HCTL = 4'd2, A_FLEN = 4'd3,
                         A_VSL = 4'd4, A_DVS = 4'd5, A_DVE = 4'd6, A_DXC = 4'd7,
                         A_WXC = 4'd8, A_WVS = 4'd9, A_WVE = 4'd10, A_BRD = 4'd11,
                         A_SKW = 4'd12, A_POL = 4'd13, A_FET = 4'd14;

  typedef struct packed {
    logic [2:0]      mode;
    logic [HW-1:0]   hper;
    logic [HW-1:0]   hsw;
    logic [PW-1:0]   flen;
    logic [PW-1:0]   vslen;
    logic [PW-1:0]   dvs;
    logic [PW-1:0]   dve;
    logic [HW-1:0]   dxs;
    logic [HW-1:0]   dxe;
    logic [HW-1:0]   wxs;
    logic [HW-1:0]   wxe;
    logic [PW-1:0]   wvs;
    logic [PW-1:0]   wve;
    logic [COLW-1:0] border;
    logic [HW-1:0]   skew;
    logic [2:0]      pol;
    logic [PW-1:0]   fetch;
  } cfg_t;

  cfg_t pend, act;
  logic en;
  logic [PW-1:0]   pix;
  logic [HW-1:0]   hcnt;
  logic [HW-1:0]   line;
  logic [CNTW-1:0] frames;

  logic wrap, hwrap;
  assign wrap  = en && (pix == act.flen - 1'b1);
  assign hwrap = (hcnt == act.hper - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MODE: pend.mode   <= cfg_wdata[31:29];
        A_HCTL: begin pend.hper <= cfg_wdata[31:16]; pend.hsw <= cfg_wdata[15:0]; end
        A_FLEN: pend.flen   <= cfg_wdata[PW-1:0];
        A_VSL:  pend.vslen  <= cfg_wdata[PW-1:0];
        A_DVS:  pend.dvs    <= cfg_wdata[PW-1:0];
        A_DVE:  pend.dve    <= cfg_wdata[PW-1:0];
        A_DXC:  begin pend.dxe <= cfg_wdata[31:16]; pend.dxs <= cfg_wdata[15:0]; end
        A_WXC:  begin pend.wxe <= cfg_wdata[31:16]; pend.wxs <= cfg_wdata[15:0]; end
        A_WVS:  pend.wvs    <= cfg_wdata[PW-1:0];
        A_WVE:  pend.wve    <= cfg_wdata[PW-1:0];
        A_BRD:  pend.border <= cfg_wdata[COLW-1:0];
        A_SKW:  pend.skew   <= cfg_wdata[HW-1:0];
        A_POL:  pend.pol    <= cfg_wdata[2:0];
        A_FET:  pend.fetch  <= cfg_wdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            act <= '0;
    else if (!en || wrap)  act <= pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (cfg_we && cfg_addr == A_EN) begin
      en <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix <= '0; hcnt <= '0; line <= '0; frames <= '0;
    end else if (!en) begin
      pix <= '0; hcnt <= '0; line <= '0; frames <= '0;
    end else if (wrap) begin
      pix <= '0; hcnt <= '0; line <= '0; frames <= frames + 1'b1;
    end else begin
      pix <= pix + 1'b1;
      if (hwrap) begin
        hcnt <= '0;
        line <= line + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  logic [PW-1:0] skew_w;
  logic hs_raw, vs_raw, in_dv, in_dh, de_raw, in_wh, in_wv;
  assign skew_w = PW'(act.skew);
  assign hs_raw = en && (hcnt < act.hsw);
  assign vs_raw = en && (pix >= skew_w) && (pix < skew_w + act.vslen);
  assign in_dv  = (pix >= act.dvs) && (pix <= act.dve);
  assign in_dh  = (hcnt >= act.dxs) && (hcnt <= act.dxe);
  assign de_raw = en && in_dv && in_dh;
  assign in_wh  = !act.mode[0] || ((hcnt >= act.wxs) && (hcnt <= act.wxe));
  assign in_wv  = !act.mode[1] || ((pix >= act.wvs) && (pix <= act.wve));

  assign win_o   = de_raw && in_wh && in_wv;
  assign pix_o   = win_o ? (pix_valid_i ? pix_i : '0) : (de_raw ? act.border : '0);
  assign hsync_o = hs_raw ^ act.pol[0];
  assign vsync_o = vs_raw ^ act.pol[1];
  assign de_o    = de_raw ^ act.pol[2];
  assign fetch_o = en && act.mode[2] && (pix == act.fetch);
  assign frame_cnt_o = en ? frames : '0;
  assign line_cnt_o  = en ? line : '0;

  // R8
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pix == '0) && (frames == $past(frames) + 1'b1));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap && hwrap) |=> (hcnt == '0) && (line == $past(line) + 1'b1));

  // R7
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_o && !wrap) |=> !fetch_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(wrap)) |-> $stable(act));

  // R10
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (pix == '0) && (hcnt == '0) && (line == '0) && (frames == '0));

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix == '0) && (frames == '0) && (line == '0));

endmodule

// File: tb/sim_pxcount_timing_gen.sv
module sim_pxcount_timing_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [23:0] pix_i = 0;
  logic pix_valid_i = 0;
  logic hsync_o, vsync_o, de_o, win_o, fetch_o;
  logic [23:0] pix_o;
  logic [15:0] frame_cnt_o, line_cnt_o;

  always #5 clk = ~clk;

  pxcount_timing_gen u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_i(pix_i), .pix_valid_i(pix_valid_i), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .win_o(win_o), .pix_o(pix_o), .fetch_o(fetch_o),
    .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o));

  typedef struct {
    int mode, hper, hsw, flen, vslen, dvs, dve, dxs, dxe, wxs, wxe, wvs, wve, border, skew, pol, fetch;
  } cfg_s;

  cfg_s pend, cur;
  int n_chk = 0, n_fail = 0;
  int t, pm, fr;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0d: got %0h expected %0h", tag, t, act, exp);
    end
  endtask

  task automatic put(input int addr, input int data);
    cfg_we = 1; cfg_addr = 4'(addr); cfg_wdata = 32'(data);
    case (addr)
      1:  pend.mode = (data >> 29) & 7;
      2:  begin pend.hper = (data >> 16) & 16'hFFFF; pend.hsw = data & 16'hFFFF; end
      3:  pend.flen = data;
      4:  pend.vslen = data;
      5:  pend.dvs = data;
      6:  pend.dve = data;
      7:  begin pend.dxe = (data >> 16) & 16'hFFFF; pend.dxs = data & 16'hFFFF; end
      8:  begin pend.wxe = (data >> 16) & 16'hFFFF; pend.wxs = data & 16'hFFFF; end
      9:  pend.wvs = data;
      10: pend.wve = data;
      11: pend.border = data & 24'hFFFFFF;
      12: pend.skew = data;
      13: pend.pol = data & 7;
      14: pend.fetch = data;
      default: ;
    endcase
  endtask

  task automatic idle_put(input int addr, input int data);
    @(negedge clk); put(addr, data);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic sched(input int tt);
    case (tt)
      100: put(1, 32'hE000_0000);
      101: put(12, 3);
      102: put(4, 12);
      103: put(5, 27);
      104: put(6, 74);
      105: put(8, (7 << 16) | 5);
      106: put(9, 39);
      107: put(10, 62);
      108: put(11, 24'hABCDEF);
      109: put(14, 6);
      110: put(13, 7);
      260: put(1, 32'h2000_0000);
      261: put(13, 2);
      262: put(14, 50);
      263: put(12, 0);
      264: put(5, 24);
      265: put(6, 71);
      266: put(8, (8 << 16) | 4);
      default: ;
    endcase
  endtask

  task automatic sweep_one();
    int h, ln;
    bit ehs, evs, ede, ewin;
    int epix;
    pix_i = 24'(t * 37 + 5);
    pix_valid_i = (t % 3) != 0;
    #1;
    h = pm % cur.hper;
    ln = pm / cur.hper;
    ehs = (h < cur.hsw);
    evs = (pm >= cur.skew) && (pm < cur.skew + cur.vslen);
    ede = (pm >= cur.dvs) && (pm <= cur.dve) && (h >= cur.dxs) && (h <= cur.dxe);
    ewin = ede && (((cur.mode & 1) == 0) || (h >= cur.wxs && h <= cur.wxe))
               && (((cur.mode & 2) == 0) || (pm >= cur.wvs && pm <= cur.wve));
    epix = ewin ? (pix_valid_i ? int'(pix_i) : 0) : (ede ? cur.border : 0);
    check(hsync_o == (ehs ^ cur.pol[0]), "R2 R6 hsync", hsync_o, ehs ^ cur.pol[0]);
    check(vsync_o == (evs ^ cur.pol[1]), "R3 R6 vsync", vsync_o, evs ^ cur.pol[1]);
    check(de_o == (ede ^ cur.pol[2]), "R4 R6 de", de_o, ede ^ cur.pol[2]);
    check(win_o == ewin, "R5 win", win_o, ewin);
    check(int'(pix_o) == epix, "R5 pixel", pix_o, epix);
    check(fetch_o == (((cur.mode & 4) != 0) && pm == cur.fetch), "R7 fetch", fetch_o,
          ((cur.mode & 4) != 0) && pm == cur.fetch);
    check(int'(frame_cnt_o) == fr, "R8 frame count", frame_cnt_o, fr);
    check(int'(line_cnt_o) == ln, "R8 line count", line_cnt_o, ln);
    if (t == 0) check(pm == 0 && frame_cnt_o == 0 && line_cnt_o == 0 && hsync_o == !cur.pol[0],
                      "R10 start", {frame_cnt_o, line_cnt_o}, 0);
    if (t == 120) check(hsync_o == 1'b1, "R9 pending polarity not yet applied", hsync_o, 1);
    if (t == 168) check(hsync_o == 1'b0, "R9 polarity applied at frame start", hsync_o, 0);
  endtask

  task automatic run(input int upto);
    while (t < upto) begin
      @(negedge clk);
      cfg_we = 0;
      sweep_one();
      sched(t);
      if (pm == cur.flen - 1) begin pm = 0; fr++; cur = pend; end
      else pm++;
      t++;
    end
  endtask

  task automatic start_engine();
    @(negedge clk); put(0, 1);
    cur = pend; t = 0; pm = 0; fr = 0;
  endtask

  task automatic idle_check(input int pol);
    @(negedge clk); cfg_we = 0; #1;
    check(hsync_o == pol[0], "R1 R6 idle hsync", hsync_o, pol[0]);
    check(vsync_o == pol[1], "R1 R6 idle vsync", vsync_o, pol[1]);
    check(de_o == pol[2], "R1 R6 idle de", de_o, pol[2]);
    check(fetch_o == 0 && win_o == 0 && pix_o == 0, "R1 idle fetch/win/pixel",
          {fetch_o, win_o, pix_o}, 0);
    check(frame_cnt_o == 0 && line_cnt_o == 0, "R1 idle counters", {frame_cnt_o, line_cnt_o}, 0);
  endtask

  initial begin
    pend = '{default: 0};
    t = 0;
    repeat (3) @(negedge clk);
    idle_check(0);
    rst_n = 1;
    idle_check(0);
    idle_put(2, (12 << 16) | 2);
    idle_put(3, 84);
    idle_put(4, 12);
    idle_put(5, 24);
    idle_put(6, 71);
    idle_put(7, (9 << 16) | 4);
    idle_put(11, 24'h123456);
    idle_put(14, 30);
    start_engine();
    run(420);
    @(negedge clk); put(0, 0);
    idle_check(2);
    start_engine();
    run(100);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule